// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps the interrupt bookkeeping of a packet network controller: an 8-bit event status register, an 8-bit interrupt enable mask, the command register and the transmit status register. It also drives a single interrupt request line toward the host. Datapath logic elsewhere in the controller sends one-cycle pulses when something happens, such as a frame received or sent, an error, a ring overwrite warning, a counter overflow or the end of a remote DMA. Each pulse latches a bit in the status register. The host reads the status register over a simple byte-wide register port and acknowledges events by writing ones to the bits it has handled.

The interrupt line is a registered level. It is recomputed every cycle from the status bits that are enabled in the mask. Bit 7 of the status register reports that the controller has been reset. It is set by any reset, it is cleared when the host issues a start command, and it never raises the interrupt line. A completed transmission clears the transmit request bit of the command register, records a clean transmit status and flags the transmit event. A read of the reset port re-initialises the block and returns zero.

Top module: `nic_irq_unit`

## Requirements
- R1: Register select codes on `host_addr` are 0 for command, 1 for status, 2 for mask, 3 for transmit status and 7 for the reset port. Read data appears on `host_rdata` in the cycle after `host_rd`, showing the register value before that edge. Reads of codes 4 to 6 return 0x00, and writes to codes 4 to 7 change no register.
- R2: While `rst` is high at a clock edge, status becomes 0x80, mask becomes 0x00, command becomes 0x22, transmit status becomes 0x00 and `irq` becomes 0.
- R3: A pulse on `evt_pulse[i]` (bit 0 frame received, 1 frame sent, 2 receive error, 3 transmit error, 4 overwrite warning, 5 counter overflow, 6 remote DMA done) sets status bit i. The bit then stays set until the host clears it.
- R4: A host write to status clears each of the low seven status bits whose write data bit is 1. Status bit 7 is never changed by such a write.
- R5: When an event pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is 1 exactly when, at the previous clock edge, the status AND mask AND 0x7F was nonzero. Status bit 7 never raises `irq`.
- R7: A command write with bit 0 (stop) equal to 0 clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R8: A pulse on `tx_done` sets transmit status to 0x01, sets status bit 1 and clears command bit 2 (transmit request). It clears bit 2 even if a command write in the same cycle sets it.
- R9: A host read of the reset port (code 7) returns 0x00 and applies the same re-initialisation as R2 at that edge. This takes precedence over event pulses in the same cycle.
- R10: `stopped` always equals command bit 0, and `tx_request` always equals command bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register select code |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| evt_pulse | input | 7 | Event pulses, one per status bit 0..6 |
| tx_done | input | 1 | Transmission completed pulse |
| irq | output | 1 | Registered interrupt request level |
| stopped | output | 1 | Command stop bit |
| tx_request | output | 1 | Command transmit request bit |

## Verification
Several properties are checked by assertions on every cycle: the relation between the enabled status bits and the one-cycle-later `irq` level, the latching of every event pulse, the write-one-to-clear rule, the start command clearing the reset flag, the transmit completion updates and the re-initialisation from both reset sources. Other behaviours can only be shown by the bench's directed scenarios, because they need a stimulus ordering with a known result. These are set-over-clear collisions, a transmit completion racing a command write, a soft reset racing an event, the inert unused select codes and the exact read-back values.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int EVT_N  = 7;
  localparam int REG_W  = EVT_N + 1;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD  = 3'd0,
    SEL_STAT = 3'd1,
    SEL_MASK = 3'd2,
    SEL_TXS  = 3'd3,
    SEL_SRST = 3'd7
  } sel_e;

  localparam int BIT_TXEV = 1;
  localparam int BIT_RSTF = REG_W - 1;
  localparam int CMD_STOP = 0;
  localparam int CMD_TXRQ = 2;
  localparam int TXS_OK   = 0;

  localparam logic [REG_W-1:0] STAT_INIT = REG_W'(1) << BIT_RSTF;
  localparam logic [REG_W-1:0] MASK_INIT = '0;
  localparam logic [REG_W-1:0] CMD_INIT  = 8'h22;
  localparam logic [REG_W-1:0] TXS_DONE  = REG_W'(1) << TXS_OK;
endpackage

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             init,
  input  logic [EVT_N-1:0] evt,
  input  logic             tx_evt,
  input  logic             clr_we,
  input  logic [EVT_N-1:0] clr_mask,
  input  logic             start_we,
  output logic [REG_W-1:0] stat_q
);
  logic [EVT_N-1:0] set_v;
  logic [EVT_N-1:0] low_q;
  logic             rstf_q;

  for (genvar g = 0; g < EVT_N; g++) begin : g_bit
    assign set_v[g] = evt[g] | (tx_evt & (g == BIT_TXEV));
    always_ff @(posedge clk) begin
      if (init)
        low_q[g] <= STAT_INIT[g];
      else
        low_q[g] <= (low_q[g] & ~(clr_we & clr_mask[g])) | set_v[g];
    end
  end

  always_ff @(posedge clk) begin
    if (init)
      rstf_q <= STAT_INIT[BIT_RSTF];
    else if (start_we)
      rstf_q <= 1'b0;
  end

  assign stat_q = {rstf_q, low_q};

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (init)
    (|set_v) |=> ((stat_q[EVT_N-1:0] & $past(set_v)) == $past(set_v)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (init)
    clr_we |=> ((stat_q[EVT_N-1:0] & $past(clr_mask & ~set_v)) == '0));

  assert_w1c_keeps_flag_R4: assert property (@(posedge clk) disable iff (init)
    (clr_we && !start_we) |=> (stat_q[BIT_RSTF] == $past(stat_q[BIT_RSTF])));

  assert_start_clears_flag_R7: assert property (@(posedge clk) disable iff (init)
    start_we |=> !stat_q[BIT_RSTF]);
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             init,
  input  logic             wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_done,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] txs_q
);
  logic [REG_W-1:0] cmd_nxt;
  logic             wr_cmd;
  logic             wr_mask;

  assign wr_cmd  = wr && (addr == SEL_CMD);
  assign wr_mask = wr && (addr == SEL_MASK);

  always_comb begin
    cmd_nxt = wr_cmd ? wdata : cmd_q;
    if (tx_done) cmd_nxt[CMD_TXRQ] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (init) begin
      mask_q <= MASK_INIT;
      cmd_q  <= CMD_INIT;
      txs_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      cmd_q <= cmd_nxt;
      if (tx_done) txs_q <= TXS_DONE;
    end
  end

  assert_tx_done_R8: assert property (@(posedge clk) disable iff (init)
    tx_done |=> (!cmd_q[CMD_TXRQ] && txs_q == TXS_DONE));
endmodule

// File: rtl/nic_irq_line.sv
module nic_irq_line
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             init,
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] mask,
  output logic             irq_q
);
  localparam logic [REG_W-1:0] IRQ_EN = (REG_W'(1) << EVT_N) - REG_W'(1);

  always_ff @(posedge clk) begin
    if (init)
      irq_q <= 1'b0;
    else
      irq_q <= |(stat & mask & IRQ_EN);
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              tx_done,
  output logic              irq,
  output logic              stopped,
  output logic              tx_request
);
  logic             soft_rst;
  logic             init;
  logic             clr_we;
  logic             start_we;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] cmd_q;
  logic [REG_W-1:0] txs_q;

  assign soft_rst = host_rd && (host_addr == SEL_SRST);
  assign init     = rst || soft_rst;
  assign clr_we   = host_wr && (host_addr == SEL_STAT);
  assign start_we = host_wr && (host_addr == SEL_CMD) && !host_wdata[CMD_STOP];

  nic_irq_status u_status (
    .clk      (clk),
    .init     (init),
    .evt      (evt_pulse),
    .tx_evt   (tx_done),
    .clr_we   (clr_we),
    .clr_mask (host_wdata[EVT_N-1:0]),
    .start_we (start_we),
    .stat_q   (stat_q)
  );

  nic_irq_regs u_regs (
    .clk     (clk),
    .init    (init),
    .wr      (host_wr),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .tx_done (tx_done),
    .mask_q  (mask_q),
    .cmd_q   (cmd_q),
    .txs_q   (txs_q)
  );

  nic_irq_line u_line (
    .clk   (clk),
    .init  (init),
    .stat  (stat_q),
    .mask  (mask_q),
    .irq_q (irq)
  );

  always_ff @(posedge clk) begin
    if (init) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      unique case (host_addr)
        SEL_CMD:  host_rdata <= cmd_q;
        SEL_STAT: host_rdata <= stat_q;
        SEL_MASK: host_rdata <= mask_q;
        SEL_TXS:  host_rdata <= txs_q;
        default:  host_rdata <= '0;
      endcase
    end
  end

  assign stopped    = cmd_q[CMD_STOP];
  assign tx_request = cmd_q[CMD_TXRQ];

  assert_hard_init_R2: assert property (@(posedge clk)
    rst |=> (stat_q == STAT_INIT && mask_q == MASK_INIT && cmd_q == CMD_INIT
             && txs_q == '0 && !irq));

  assert_soft_init_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (host_rdata == '0 && stat_q == STAT_INIT && mask_q == MASK_INIT
                  && cmd_q == CMD_INIT));

  assert_irq_low_R6: assert property (@(posedge clk) disable iff (rst)
    !(|($past(stat_q[EVT_N-1:0]) & $past(mask_q[EVT_N-1:0]))) |-> !irq);

  assert_irq_high_R6: assert property (@(posedge clk) disable iff (init)
    (|(stat_q[EVT_N-1:0] & mask_q[EVT_N-1:0])) |=> irq);

  assert_mask_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == SEL_MASK) |=> (host_rdata == $past(mask_q)));
endmodule

// File: tb/nic_irq_unit_bench.sv
module nic_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [6:0] evt_pulse = 7'h00;
  logic       tx_done = 1'b0;
  logic       irq;
  logic       stopped;
  logic       tx_request;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nic_irq_unit u_nic_irq_unit (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .evt_pulse  (evt_pulse),
    .tx_done    (tx_done),
    .irq        (irq),
    .stopped    (stopped),
    .tx_request (tx_request)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = 7'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R2 irq after reset", {7'h0, irq}, 8'h00);
    check("R10 stopped after reset", {7'h0, stopped}, 8'h00);
    check("R10 tx_request after reset", {7'h0, tx_request}, 8'h00);
    rd(3'd1, v); check("R2 status init", v, 8'h80);
    rd(3'd2, v); check("R2 mask init", v, 8'h00);
    rd(3'd0, v); check("R2 command init", v, 8'h22);
    rd(3'd3, v); check("R2 tx status init", v, 8'h00);
  endtask

  task automatic t_flag_no_irq;
    wr(3'd2, 8'hFF);
    idle(2);
    check("R6 bit7 never raises irq", {7'h0, irq}, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_start;
    logic [7:0] v;
    wr(3'd0, 8'h21);
    check("R10 stopped follows bit0", {7'h0, stopped}, 8'h01);
    rd(3'd1, v); check("R7 stop write keeps flag", v, 8'h80);
    wr(3'd0, 8'h22);
    check("R10 stopped cleared", {7'h0, stopped}, 8'h00);
    rd(3'd1, v); check("R7 start clears flag", v, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] v;
    pulse(7'h05);
    rd(3'd1, v); check("R3 events latched", v, 8'h05);
    check("R6 masked off no irq", {7'h0, irq}, 8'h00);
    pulse(7'h40);
    idle(1);
    rd(3'd1, v); check("R3 events held", v, 8'h45);
  endtask

  task automatic t_mask;
    wr(3'd2, 8'h02);
    idle(1);
    check("R6 disjoint mask no irq", {7'h0, irq}, 8'h00);
    wr(3'd2, 8'h04);
    check("R6 irq one cycle late", {7'h0, irq}, 8'h00);
    idle(1);
    check("R6 irq asserted", {7'h0, irq}, 8'h01);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    wr(3'd1, 8'h04);
    rd(3'd1, v); check("R4 write one clears", v, 8'h41);
    check("R6 irq drops after clear", {7'h0, irq}, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); check("R4 clear all low bits", v, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    pulse(7'h08);
    host_wr = 1'b1; host_addr = 3'd1; host_wdata = 8'h08; evt_pulse = 7'h08;
    @(negedge clk);
    host_wr = 1'b0; evt_pulse = 7'h00;
    rd(3'd1, v); check("R5 set beats clear", v, 8'h08);
    wr(3'd1, 8'h08);
    rd(3'd1, v); check("R4 cleared after collision", v, 8'h00);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    wr(3'd0, 8'h26);
    check("R10 tx_request set", {7'h0, tx_request}, 8'h01);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    check("R8 tx_request cleared", {7'h0, tx_request}, 8'h00);
    rd(3'd0, v); check("R8 command bit2 cleared", v, 8'h22);
    rd(3'd3, v); check("R8 tx status ok", v, 8'h01);
    rd(3'd1, v); check("R8 tx event flagged", v, 8'h02);
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h26; tx_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; tx_done = 1'b0;
    check("R8 done beats command write", {7'h0, tx_request}, 8'h00);
    wr(3'd1, 8'h7F);
  endtask

  task automatic t_soft;
    logic [7:0] v;
    wr(3'd2, 8'hFF);
    pulse(7'h11);
    idle(1);
    check("R6 irq before soft reset", {7'h0, irq}, 8'h01);
    rd(3'd7, v); check("R9 reset port reads zero", v, 8'h00);
    check("R9 irq cleared", {7'h0, irq}, 8'h00);
    rd(3'd1, v); check("R9 status reinit", v, 8'h80);
    rd(3'd2, v); check("R9 mask reinit", v, 8'h00);
    rd(3'd0, v); check("R9 command reinit", v, 8'h22);
    rd(3'd3, v); check("R9 tx status reinit", v, 8'h00);
    wr(3'd1, 8'h80);
    rd(3'd1, v); check("R4 bit7 immune to clear", v, 8'h80);
    host_rd = 1'b1; host_addr = 3'd7; evt_pulse = 7'h01;
    @(negedge clk);
    host_rd = 1'b0; evt_pulse = 7'h00;
    rd(3'd1, v); check("R9 soft reset beats event", v, 8'h80);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    wr(3'd5, 8'h55);
    wr(3'd7, 8'hFF);
    rd(3'd2, v); check("R1 unused write leaves mask", v, 8'h00);
    rd(3'd0, v); check("R1 unused write leaves command", v, 8'h22);
    rd(3'd4, v); check("R1 unused read zero", v, 8'h00);
    rd(3'd1, v); check("R1 unused write leaves status", v, 8'h80);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flag_no_irq();
    t_start();
    t_events();
    t_mask();
    t_w1c();
    t_collide();
    t_tx();
    t_soft();
    t_unused();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5000; i++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule